// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator With Register Window

This block produces one or two active-high pulse-width modulated outputs, each set up through a small word-addressed register window. Each channel slows the input clock through a programmable prescaler. It then counts a programmable number of prescaled ticks per output period, and drives its output high for a programmed number of those ticks at the start of each period.

Software writes a channel's registers and then raises that channel's enable pin. The channel copies the register values into working copies at the start of every period, so a new setting written while the channel runs takes effect at the next period boundary and never cuts a pulse short. When enable drops, a per-channel stop-mode bit picks the behaviour. The channel either stops on the next clock edge, or finishes the period in progress and then holds its output low. A separate bit holds the output high for the whole period, whatever the duty count.

The register bus is a plain single-cycle port with no back-pressure. A write is accepted on every clock edge where the write strobe is high, and read data is a combinational function of the address. There is no valid/ready stream anywhere in the block.

Top module: `pwm_unit`

## Requirements
- R1: Per-channel registers sit at word addresses 0 (control: prescale in bits [5:0], stop-mode bit 6), 1 (duty: count in bits [9:0], full-duty bit 10) and 2 (period value in bits [9:0]). Each register reads back the last value written, with unused bits reading zero, and word address 3 reads zero.
- R2: The second channel's registers sit at word addresses 4, 5 and 6 (byte offsets 0x10, 0x14, 0x18). Writing them leaves the first channel's registers and output untouched, and the second channel runs from its own enable pin and drives its own output.
- R3: A channel's first period starts on the clock edge that samples its enable high. Each period lasts (prescale+1)*(period+1) clock cycles and repeats while enable stays high.
- R4: In each period the output is high for the first (prescale+1)*duty cycles and low for the rest.
- R5: With the full-duty bit set, the output is high for the whole period, whatever the duty count.
- R6: A duty count of 0 with the full-duty bit clear keeps the output low. A duty count greater than period+1 keeps it high for the whole period.
- R7: With the stop-mode bit set, a low enable sampled on a clock edge drives the output low from that edge on. A later enable starts a fresh period.
- R8: With the stop-mode bit clear, a low enable lets the current period run to its end, after which the output stays low.
- R9: Duty, period and prescale values written while a channel runs take effect only at the next period boundary.
- R10: Reset clears all registers to zero and holds the outputs low. A disabled channel's output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock for registers and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per clock edge |
| bus_addr | input | 3 | Word address inside the register window |
| bus_wdata | input | 11 | Write data |
| bus_rdata | output | 11 | Read data for bus_addr, combinational |
| ch_en | input | NUM_CH | Per-channel enable |
| pwm_out | output | NUM_CH | Per-channel active-high output |

## Verification
The assertions take for granted that the enable pins and the bus signals are synchronous to clk and settle between edges. They also assume the stop-mode bit is treated as the channel's live stop choice at the edge where enable is seen low. The stimulus drives every input on the falling clock edge and samples outputs on the falling edge, so each change lands on one known rising edge. Register writes during a running period are spaced so that each one lands before the boundary the requirement refers to.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Word index of each register inside one channel's window
  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_DUTY   = 2'd1;
  localparam logic [1:0] REG_PERIOD = 2'd2;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R3: the divider never runs past its limit, so each tick is (limit+1) cycles
  assert_prescale_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> cnt <= limit);
endmodule

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int PRE_W  = 6,
  parameter int CNT_W  = 10,
  localparam int DW    = CNT_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic [2:0]                   bus_addr,
  input  logic [DW-1:0]                bus_wdata,
  output logic [DW-1:0]                bus_rdata,
  output logic [NUM_CH-1:0][PRE_W-1:0] pre_q,
  output logic [NUM_CH-1:0]            abrupt_q,
  output logic [NUM_CH-1:0][CNT_W-1:0] duty_q,
  output logic [NUM_CH-1:0]            full_q,
  output logic [NUM_CH-1:0][CNT_W-1:0] per_q
);
  logic       ch_sel;
  logic [1:0] rsel;
  logic       hit;
  logic [NUM_CH-1:0][DW-1:0] rd_word;

  assign ch_sel = bus_addr[2];
  assign rsel   = bus_addr[1:0];
  assign hit    = (32'(ch_sel) < NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_here;
    assign wr_here = bus_wr && hit && (ch_sel == 1'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pre_q[c]    <= '0;
        abrupt_q[c] <= 1'b0;
        duty_q[c]   <= '0;
        full_q[c]   <= 1'b0;
        per_q[c]    <= '0;
      end else if (wr_here) begin
        case (rsel)
          REG_CTRL: begin
            pre_q[c]    <= bus_wdata[PRE_W-1:0];
            abrupt_q[c] <= bus_wdata[PRE_W];
          end
          REG_DUTY: begin
            duty_q[c] <= bus_wdata[CNT_W-1:0];
            full_q[c] <= bus_wdata[CNT_W];
          end
          REG_PERIOD: per_q[c] <= bus_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end

    always_comb begin
      rd_word[c] = '0;
      case (rsel)
        REG_CTRL:   rd_word[c][PRE_W:0] = {abrupt_q[c], pre_q[c]};
        REG_DUTY:   rd_word[c]          = {full_q[c], duty_q[c]};
        REG_PERIOD: rd_word[c][CNT_W-1:0] = per_q[c];
        default:    rd_word[c] = '0;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit && (ch_sel == 1'(c))) bus_rdata = rd_word[c];
    end
  end

  // R1: a control write on channel 0 lands in both control fields
  assert_ctrl_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !ch_sel && rsel == REG_CTRL)
      |=> {abrupt_q[0], pre_q[0]} == $past(bus_wdata[PRE_W:0]));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int PRE_W = 6,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             abrupt,
  input  logic [PRE_W-1:0] pre_reg,
  input  logic [CNT_W-1:0] duty_reg,
  input  logic             full_reg,
  input  logic [CNT_W-1:0] per_reg,
  output logic             pwm_out
);
  logic             running;
  logic [PRE_W-1:0] pre_act;
  logic [CNT_W-1:0] duty_act;
  logic [CNT_W-1:0] per_act;
  logic             full_act;
  logic [CNT_W-1:0] pcnt;
  logic             tick;
  logic             start;
  logic             halt;
  logic             boundary;

  assign start    = !running && en;
  assign halt     = running && !en && abrupt;
  assign boundary = running && tick && (pcnt == per_act);

  pwm_tick_gen #(.W(PRE_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!running || halt || boundary),
    .limit (pre_act),
    .tick  (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      pre_act  <= '0;
      duty_act <= '0;
      per_act  <= '0;
      full_act <= 1'b0;
      pcnt     <= '0;
    end else if (start || (boundary && en)) begin
      running  <= 1'b1;
      pre_act  <= pre_reg;
      duty_act <= duty_reg;
      per_act  <= per_reg;
      full_act <= full_reg;
      pcnt     <= '0;
    end else if (halt || boundary) begin
      running <= 1'b0;
      pcnt    <= '0;
    end else if (running && tick) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  assign pwm_out = running && (full_act || (pcnt < duty_act));

  // R3: the period counter stays within the latched period value
  assert_pcnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= per_act);

  // R7: an abrupt stop silences the output on the very next edge
  assert_abrupt_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !en && abrupt) |=> !pwm_out);

  // R8: a graceful stop keeps the channel running until the period ends
  assert_graceful_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !en && !abrupt && !boundary) |=> running);

  // R9: working values only change at a start or a period boundary
  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !boundary)
      |=> ($stable(duty_act) && $stable(per_act) && $stable(pre_act) && $stable(full_act)));

  // R10: the output is low while reset is held
  assert_reset_low_R10: assert property (@(posedge clk) !rst_n |-> !pwm_out);
endmodule

// File: rtl/pwm_unit.sv
module pwm_unit #(
  parameter int NUM_CH = 2,
  parameter int PRE_W  = 6,
  parameter int CNT_W  = 10,
  localparam int DW    = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NUM_CH-1:0] ch_en,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0][PRE_W-1:0] pre_q;
  logic [NUM_CH-1:0]            abrupt_q;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_q;
  logic [NUM_CH-1:0]            full_q;
  logic [NUM_CH-1:0][CNT_W-1:0] per_q;

  pwm_regbank #(.NUM_CH(NUM_CH), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pre_q     (pre_q),
    .abrupt_q  (abrupt_q),
    .duty_q    (duty_q),
    .full_q    (full_q),
    .per_q     (per_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_channel #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ch_en[c]),
      .abrupt   (abrupt_q[c]),
      .pre_reg  (pre_q[c]),
      .duty_reg (duty_q[c]),
      .full_reg (full_q[c]),
      .per_reg  (per_q[c]),
      .pwm_out  (pwm_out[c])
    );
  end
endmodule

// File: tb/pwm_unit_bench.sv
`timescale 1ns/1ps
module pwm_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [10:0] bus_wdata = '0;
  logic [10:0] bus_rdata;
  logic [1:0]  ch_en = '0;
  logic [1:0]  pwm_out;

  int total = 0;
  int bad = 0;
  logic got_tr [0:255];
  logic exp_tr [0:255];

  always #2 clk = ~clk;

  pwm_unit u_pwm_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_en(ch_en), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(addr); bus_wdata = 11'(data);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    bus_addr = 3'(addr);
    #1 data = int'(bus_rdata);
  endtask

  function automatic logic model(input int i, input int pre, input int pv,
                                 input int duty, input bit full);
    int p = (pre + 1) * (pv + 1);
    int pos = i % p;
    return full || (pos < duty * (pre + 1));
  endfunction

  task automatic cmp_trace(input int n, input string req);
    int first = -1;
    for (int i = 0; i < n; i++) if (got_tr[i] !== exp_tr[i] && first < 0) first = i;
    if (first < 0) chk(1'b1, req, 0, 0);
    else begin
      $display("  mismatch at sample %0d", first);
      chk(1'b0, req, int'(got_tr[first]), int'(exp_tr[first]));
    end
  endtask

  // R10: registers and outputs after reset
  task automatic t_reset;
    int v;
    chk(pwm_out == 2'b00, "R10 outputs low after reset", int'(pwm_out), 0);
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      chk(v == 0, "R10 register zero after reset", v, 0);
    end
  endtask

  // R1 / R2: field widths, read-back, second window
  task automatic t_regs;
    int v;
    wr(0, 11'h7FF); rd(0, v); chk(v == 'h07F, "R1 control read-back", v, 'h07F);
    wr(1, 11'h7FF); rd(1, v); chk(v == 'h7FF, "R1 duty read-back", v, 'h7FF);
    wr(2, 11'h7FF); rd(2, v); chk(v == 'h3FF, "R1 period read-back", v, 'h3FF);
    rd(3, v);       chk(v == 0, "R1 unused word reads zero", v, 0);
    wr(4, 11'h055); rd(4, v); chk(v == 'h055, "R2 second control read-back", v, 'h055);
    wr(6, 11'h123); rd(6, v); chk(v == 'h123, "R2 second period read-back", v, 'h123);
    rd(0, v);       chk(v == 'h07F, "R2 first control untouched", v, 'h07F);
    rd(2, v);       chk(v == 'h3FF, "R2 first period untouched", v, 'h3FF);
    chk(pwm_out == 2'b00, "R10 disabled outputs stay low", int'(pwm_out), 0);
  endtask

  // R3..R7: run channel 0, compare the trace, then stop abruptly mid-period
  task automatic t_wave(input int pre, input int pv, input int duty, input bit full,
                        input string req);
    int p = (pre + 1) * (pv + 1);
    int n = p + p / 2 + 1;
    wr(0, 'h40 | pre);
    wr(1, (int'(full) << 10) | duty);
    wr(2, pv);
    @(negedge clk); ch_en[0] = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got_tr[i] = pwm_out[0];
      exp_tr[i] = model(i, pre, pv, duty, full);
    end
    cmp_trace(n, req);
    ch_en[0] = 1'b0;
    @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R7 abrupt stop low next cycle", int'(pwm_out[0]), 0);
    repeat (3) @(negedge clk);
  endtask

  // R8: graceful stop finishes the period
  task automatic t_graceful;
    wr(0, 1);
    wr(1, 2);
    wr(2, 4);
    @(negedge clk); ch_en[0] = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      got_tr[i] = pwm_out[0];
      exp_tr[i] = (i < 10) ? model(i, 1, 4, 2, 1'b0) : 1'b0;
      if (i == 3) ch_en[0] = 1'b0;
    end
    cmp_trace(20, "R8 graceful stop ends at boundary");
  endtask

  // R9: update while running applies at next boundary
  task automatic t_update;
    wr(0, 'h40);
    wr(1, 2);
    wr(2, 9);
    @(negedge clk); ch_en[0] = 1'b1;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      got_tr[i] = pwm_out[0];
      exp_tr[i] = (i < 10) ? (i < 2) : 1'b1;
      if (i == 4) begin bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 11'd7; end
      if (i == 5) begin bus_addr = 3'd2; bus_wdata = 11'd4; end
      if (i == 6) bus_wr = 1'b0;
    end
    cmp_trace(25, "R9 new values at next boundary");
    ch_en[0] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // R2: second channel runs alone
  task automatic t_second;
    bit quiet = 1'b1;
    wr(4, 'h40);
    wr(5, 1);
    wr(6, 3);
    @(negedge clk); ch_en[1] = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      got_tr[i] = pwm_out[1];
      exp_tr[i] = model(i, 0, 3, 1, 1'b0);
      if (pwm_out[0]) quiet = 1'b0;
    end
    cmp_trace(12, "R2 second channel waveform");
    chk(quiet, "R2 first output quiet", int'(!quiet), 0);
    ch_en[1] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_wave(0, 9, 3, 1'b0, "R3 R4 pre0 period10 duty3");
    t_wave(2, 4, 2, 1'b0, "R3 R4 pre2 period5 duty2");
    t_wave(1, 3, 1, 1'b1, "R5 full-duty bit");
    t_wave(0, 5, 0, 1'b0, "R6 zero duty stays low");
    t_wave(0, 9, 20, 1'b0, "R6 oversize duty is full");
    t_graceful;
    t_update;
    t_second;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule